// File: doc/BRIEF.md
# Pulse-Length Reset and Power-Down Discriminator

This block watches one active-low pin that carries two commands. The command depends on how long the pin stays low. A short low pulse resets the converter's frame logic. A long low pulse puts the converter into power-down. The pin is asynchronous. The internal reset and the serial-output disable rise as soon as the pin falls, without waiting for a clock edge. The block measures the low time in system clock cycles through a two-stage synchroniser and releases reset on a clock edge.

When the pin falls while the block is running, it emits a one-cycle abort strobe to the conversion logic. After a plain reset, it releases as soon as the synchronised pin is high again and a minimum reset window has passed. After power-down, it first holds a counted power-up delay. The converter then produces four conversions that are known to be bad. The block counts the conversion-complete strobes and raises a data-valid flag only on the fifth one.

Top module: `pwr_rst_discriminator`

## Requirements
- R1: When `pin_n` falls, `rst_o` and `sdo_off` go high and `data_valid` goes low before the next rising clock edge. While `pin_n` is low after reset, `rst_o` and `sdo_off` read 1 and `data_valid` reads 0.
- R2: Each falling edge of `pin_n` seen while the block is running gives exactly one `conv_abort` pulse. The pulse is one clock wide and visible right after the first rising edge that follows the fall (edge 0).
- R3: Let L be the number of rising edges during which `pin_n` is low, counted from edge 0, with L at most PD_CYCLES-2. Then `rst_o` and `sdo_off` fall right after edge max(L+2, RST_CYCLES).
- R4: A low glitch that no rising edge samples (L = 0) still holds reset for a full RST_CYCLES window, so `rst_o` falls right after edge RST_CYCLES.
- R5: If L is PD_CYCLES-1 or more, `pd_o` rises right after edge PD_CYCLES. If L is at most PD_CYCLES-2, `pd_o` stays low for the whole event.
- R6: After a power-down, `rst_o`, `sdo_off` and `pd_o` all fall right after edge L+2+WAKE_CYCLES.
- R7: `data_valid` rises right after the edge that samples the fifth high `conv_done` taken while reset is low. Strobes sampled while `rst_o` is high are not counted.
- R8: Once high, `data_valid` stays high through any number of further strobes until the next fall of `pin_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pin_n | input | 1 | Asynchronous active-low reset / power-down pin |
| conv_done | input | 1 | One-cycle conversion-complete strobe from the sequencer |
| rst_o | output | 1 | Internal reset to the frame sequencer; asynchronous assert, synchronous release |
| pd_o | output | 1 | Power-down state, held through the power-up delay |
| sdo_off | output | 1 | Forces the serial data output to high impedance |
| conv_abort | output | 1 | One-cycle strobe that aborts the conversion in progress |
| data_valid | output | 1 | High once the warm-up conversions have passed |

## Verification
The bench probes pulse lengths on both sides of the power-down threshold: PD_CYCLES-2 and PD_CYCLES-1 edges. A comparator off by one either misses the power-down or powers down on a reset pulse. It drives a glitch that no clock edge samples. A design that trusts only the synchronised pin would miss that glitch, or would release after fewer than RST_CYCLES edges. Each release edge is measured exactly against max(L+2, RST_CYCLES) or L+2+WAKE_CYCLES, so a dropped synchroniser stage or a short power-up delay shows as a wrong edge number. `conv_done` is held high through every reset window and the strobe count is swept across four and five, which exposes a warm-up counter that is cleared wrongly or that fires one strobe early.

// File: rtl/pwr_rst_discriminator.sv
module pwr_rst_discriminator #(
  parameter int RST_CYCLES   = 8,
  parameter int PD_CYCLES    = 64,
  parameter int WAKE_CYCLES  = 32,
  parameter int INVALID_CONV = 4
) (
  input  logic clk,
  input  logic pin_n,
  input  logic conv_done,
  output logic rst_o,
  output logic pd_o,
  output logic sdo_off,
  output logic conv_abort,
  output logic data_valid
);

  localparam int MAXC0 = (PD_CYCLES > RST_CYCLES) ? PD_CYCLES : RST_CYCLES;
  localparam int MAXC  = (WAKE_CYCLES > MAXC0) ? WAKE_CYCLES : MAXC0;
  localparam int CW    = $clog2(MAXC + 1);
  localparam int WW    = $clog2(INVALID_CONV + 1);

  typedef enum logic [1:0] {S_RUN = 2'd0, S_RST = 2'd1, S_PD = 2'd2, S_WAKE = 2'd3} st_t;

  logic          pin_m, pin_s;
  logic          arst_q, abort_q, dv_q;
  st_t           st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic [WW-1:0] wcnt;

  always_ff @(posedge clk) begin
    pin_m <= pin_n;
    pin_s <= pin_m;
  end

  always_comb begin
    st_nx  = st;
    cnt_nx = (cnt == CW'(MAXC)) ? cnt : cnt + 1'b1;
    case (st)
      S_RUN: begin
        cnt_nx = '0;
        if (arst_q) st_nx = S_RST;
      end
      S_RST: begin
        if (!pin_s && cnt == CW'(PD_CYCLES - 1))      st_nx = S_PD;
        else if (pin_s && cnt >= CW'(RST_CYCLES - 1)) st_nx = S_RUN;
      end
      S_PD: begin
        cnt_nx = '0;
        if (pin_s) st_nx = S_WAKE;
      end
      S_WAKE: begin
        if (!pin_s) begin
          st_nx  = S_RST;
          cnt_nx = '0;
        end else if (cnt == CW'(WAKE_CYCLES - 1)) begin
          st_nx = S_RUN;
        end
      end
      default: begin
        st_nx  = S_RST;
        cnt_nx = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    st      <= st_nx;
    cnt     <= cnt_nx;
    abort_q <= (st == S_RUN) && arst_q;
  end

  always_ff @(posedge clk or negedge pin_n)
    if (!pin_n) arst_q <= 1'b1;
    else        arst_q <= (st_nx != S_RUN);

  always_ff @(posedge clk)
    if (st != S_RUN || arst_q)                            wcnt <= '0;
    else if (conv_done && wcnt != WW'(INVALID_CONV))     wcnt <= wcnt + 1'b1;

  always_ff @(posedge clk or negedge pin_n)
    if (!pin_n)                                          dv_q <= 1'b0;
    else if (st != S_RUN || arst_q)                      dv_q <= 1'b0;
    else if (conv_done && wcnt == WW'(INVALID_CONV))     dv_q <= 1'b1;

  assign rst_o      = arst_q;
  assign sdo_off    = arst_q;
  assign pd_o       = (st == S_PD) || (st == S_WAKE);
  assign conv_abort = abort_q;
  assign data_valid = dv_q;

  assert_pd_under_rst_R5: assert property (@(posedge clk) disable iff (!pin_n)
    pd_o |-> rst_o);

  assert_abort_single_R2: assert property (@(posedge clk) disable iff (!pin_n)
    conv_abort |=> !conv_abort);

  assert_dv_low_in_rst_R7: assert property (@(posedge clk) disable iff (!pin_n)
    rst_o |-> !data_valid);

  assert_release_pin_high_R3: assert property (@(posedge clk) disable iff (!pin_n)
    $fell(rst_o) |-> $past(pin_s));

  assert_dv_on_strobe_R8: assert property (@(posedge clk) disable iff (!pin_n)
    $rose(data_valid) |-> $past(conv_done));

endmodule

// File: tb/pwr_rst_discriminator_tb_top.sv
`timescale 1ns/1ps
module pwr_rst_discriminator_tb_top;
  localparam int RST_CYCLES   = 8;
  localparam int PD_CYCLES    = 64;
  localparam int WAKE_CYCLES  = 32;
  localparam int INVALID_CONV = 4;

  logic clk = 1'b0;
  logic pin_n, conv_done;
  logic rst_o, pd_o, sdo_off, conv_abort, data_valid;
  int   checks = 0, fails = 0;
  int   strobes = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_rst_discriminator #(
    .RST_CYCLES(RST_CYCLES), .PD_CYCLES(PD_CYCLES),
    .WAKE_CYCLES(WAKE_CYCLES), .INVALID_CONV(INVALID_CONV)
  ) dut_i (
    .clk(clk), .pin_n(pin_n), .conv_done(conv_done), .rst_o(rst_o), .pd_o(pd_o),
    .sdo_off(sdo_off), .conv_abort(conv_abort), .data_valid(data_valid)
  );

  function automatic int exp_release(int len);
    if (len >= PD_CYCLES - 1) return len + 2 + WAKE_CYCLES;
    return (len + 2 > RST_CYCLES) ? len + 2 : RST_CYCLES;
  endfunction

  function automatic bit exp_pd(int len);
    return len >= PD_CYCLES - 1;
  endfunction

  function automatic bit exp_dv(int n);
    return n >= INVALID_CONV + 1;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_event(int len);
    int rel = -1, pd_n = -1, ab_cnt = 0, ab_n = -1;
    @(negedge clk);
    conv_done = 1'b1;
    pin_n = 1'b0;
    #1;
    check(rst_o == 1'b1, "R1 rst_o async", int'(rst_o), 1);
    check(sdo_off == 1'b1, "R1 sdo_off async", int'(sdo_off), 1);
    check(data_valid == 1'b0, "R1 data_valid cleared", int'(data_valid), 0);
    if (len == 0) begin
      #1 pin_n = 1'b1;
    end
    for (int n = 0; n < 400; n++) begin
      @(posedge clk);
      #1;
      if (conv_abort) begin ab_cnt++; ab_n = n; end
      if (pd_o && pd_n < 0) pd_n = n;
      if (!rst_o) begin rel = n; break; end
      if (n == len - 1) begin
        @(negedge clk);
        pin_n = 1'b1;
      end
    end
    @(negedge clk);
    conv_done = 1'b0;
    strobes = 0;
    if (len == 0) check(rel == exp_release(len), "R4 glitch release edge", rel, exp_release(len));
    else if (exp_pd(len)) check(rel == exp_release(len), "R6 power-up release edge", rel, exp_release(len));
    else check(rel == exp_release(len), "R3 reset release edge", rel, exp_release(len));
    check(sdo_off == 1'b0 && pd_o == 1'b0, "R6 sdo_off/pd_o low after release", int'({sdo_off, pd_o}), 0);
    if (exp_pd(len)) check(pd_n == PD_CYCLES, "R5 power-down edge", pd_n, PD_CYCLES);
    else check(pd_n < 0, "R5 no power-down", pd_n, -1);
    check(ab_cnt == 1 && ab_n == 0, "R2 abort pulse count", ab_cnt * 100 + ab_n, 100);
    check(data_valid == 1'b0, "R7 strobes in reset ignored", int'(data_valid), 0);
  endtask

  task automatic strobe(int gap);
    repeat (gap) @(negedge clk);
    @(negedge clk);
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    strobes++;
    #1;
    if (strobes > INVALID_CONV + 1)
      check(data_valid == exp_dv(strobes), "R8 data_valid held", int'(data_valid), int'(exp_dv(strobes)));
    else
      check(data_valid == exp_dv(strobes), "R7 data_valid warm-up", int'(data_valid), int'(exp_dv(strobes)));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C1A));
    pin_n = 1'b0;
    conv_done = 1'b0;
    repeat (20) @(negedge clk);
    #1;
    check(rst_o == 1'b1 && sdo_off == 1'b1, "R1 reset state rst/sdo", int'({rst_o, sdo_off}), 3);
    check(pd_o == 1'b0, "R5 reset state pd_o", int'(pd_o), 0);
    check(data_valid == 1'b0, "R1 reset state data_valid", int'(data_valid), 0);
    @(negedge clk);
    pin_n = 1'b1;
    for (int i = 0; i < 50 && rst_o; i++) @(negedge clk);
    check(rst_o == 1'b0, "R3 initial release", int'(rst_o), 0);

    run_event(0);
    run_event(3);
    run_event(10);
    run_event(PD_CYCLES - 2);
    run_event(PD_CYCLES - 1);
    for (int s = 0; s < 8; s++) strobe(s % 3);
    run_event(PD_CYCLES + 5);
    for (int s = 0; s < 5; s++) strobe(0);

    for (int it = 0; it < 25; it++) begin
      run_event(int'($urandom_range(0, PD_CYCLES + 10)));
      for (int s = 0, ns = int'($urandom_range(0, 8)); s < ns; s++)
        strobe(int'($urandom_range(0, 4)));
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule